// File: doc/BRIEF.md
# Outstanding Burst Limiter

This block sits on the address and response channels between an AXI manager and an AXI subordinate. It keeps a count of the read bursts and write bursts that have been accepted by the subordinate and have not yet completed. It enforces three ceilings at the same time: one on reads, one on writes, and one on their sum. The ceilings are set by parameters. A burst counts once, whatever its length. A read completes on the response beat that carries the last flag. A write completes on its write response.

When a new burst would break a ceiling, the block stops it at both edges. Ready stays low toward the manager, and valid stays low toward the subordinate. A request that has already been shown to the subordinate stays shown until that handshake completes. When a read and a write both ask for the last free combined slot in the same cycle, they take turns. The read response and write response channels, and the address payloads, pass through unchanged. The write data channel is not routed through this block.

Top module: `ostd_burst_limiter`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets both counters to zero and clears any held request. After reset, the first contested slot goes to the read side.
- R2: `rd_count` rises by one on each cycle in which the subordinate read address handshakes (s_arvalid and s_arready). It falls by one on each read data handshake whose last flag is 1. A read data beat with the last flag at 0 leaves it unchanged.
- R3: `wr_count` rises by one on each subordinate write address handshake. It falls by one on each write response handshake.
- R4: While `rd_count` equals RD_MAX and no read completes in that cycle, a new read request sees m_arready low and s_arvalid low.
- R5: While `wr_count` equals WR_MAX and no write completes in that cycle, a new write request sees m_awready low and s_awvalid low, even if the combined ceiling has room.
- R6: A new request is blocked when the combined count (plus any request held toward the subordinate) has reached ALL_MAX, even if its own direction has room.
- R7: A completion in a cycle frees its slot in that same cycle. A new burst of the same or the other direction can be admitted in that cycle, and the count moves by the net amount.
- R8: When a new read and a new write both pass their own ceilings but only one combined slot is free, only one is admitted. The winner alternates between conflicts, starting with read.
- R9: Once s_arvalid or s_awvalid is high without ready, it stays high in the next cycle, even if the ceilings are now full. This holds as long as the manager keeps its valid high.
- R10: A manager address handshake happens in exactly the cycles of the matching subordinate address handshake. The addresses are passed through unchanged.
- R11: The read response signals (valid, last, ready) and the write response signals (valid, ready) are passed straight through between the two sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_arvalid | input | 1 | Read address valid from the manager |
| m_arready | output | 1 | Read address ready to the manager |
| m_araddr | input | ADDR_W | Read address from the manager |
| m_awvalid | input | 1 | Write address valid from the manager |
| m_awready | output | 1 | Write address ready to the manager |
| m_awaddr | input | ADDR_W | Write address from the manager |
| m_rvalid | output | 1 | Read data valid to the manager |
| m_rready | input | 1 | Read data ready from the manager |
| m_rlast | output | 1 | Last beat of the read burst, to the manager |
| m_bvalid | output | 1 | Write response valid to the manager |
| m_bready | input | 1 | Write response ready from the manager |
| s_arvalid | output | 1 | Read address valid to the subordinate |
| s_arready | input | 1 | Read address ready from the subordinate |
| s_araddr | output | ADDR_W | Read address to the subordinate |
| s_awvalid | output | 1 | Write address valid to the subordinate |
| s_awready | input | 1 | Write address ready from the subordinate |
| s_awaddr | output | ADDR_W | Write address to the subordinate |
| s_rvalid | input | 1 | Read data valid from the subordinate |
| s_rready | output | 1 | Read data ready to the subordinate |
| s_rlast | input | 1 | Last beat of the read burst, from the subordinate |
| s_bvalid | input | 1 | Write response valid from the subordinate |
| s_bready | output | 1 | Write response ready to the subordinate |
| rd_count | output | CW | Read bursts currently outstanding |
| wr_count | output | CW | Write bursts currently outstanding |

## Verification
The assertions assume the manager follows the AXI valid rule: once it raises an address valid, it keeps it high until ready. They also assume the subordinate never returns more last-flagged read beats or write responses than there are bursts outstanding. The vector table keeps to both rules. A request that loses arbitration or waits on a low subordinate ready is re-driven in the next row, and completions are driven only while the matching counter is above zero.

// File: rtl/ostd_lim_pkg.sv
package ostd_lim_pkg;
    typedef enum logic {
        PRI_RD = 1'b0,
        PRI_WR = 1'b1
    } pri_e;

    localparam int unsigned DIR_RD = 0;
    localparam int unsigned DIR_WR = 1;
    localparam int unsigned NDIR   = 2;
endpackage

// File: rtl/ostd_lim_gate.sv
// Per-channel address gate: passes a request only when admitted, and keeps a
// presented request on the subordinate side until its handshake.
module ostd_lim_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic dn_ready,
    input  logic admit,
    output logic dn_valid,
    output logic up_ready,
    output logic fire,
    output logic held,
    output logic want
);
    typedef struct packed {
        logic held;
    } gate_s;

    gate_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        dn_valid = up_valid & (st_q.held | admit);
        up_ready = dn_ready & (st_q.held | admit);
        fire     = dn_valid & dn_ready;
        held     = st_q.held;
        want     = up_valid & ~st_q.held;
        st_d.held = dn_valid & ~dn_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ostd_lim_admit.sv
// Admission: per-direction and combined ceilings, with turn-taking on the last
// combined slot. Completions in the current cycle count as freed slots.
module ostd_lim_admit
    import ostd_lim_pkg::*;
#(
    parameter int unsigned RD_MAX  = 3,
    parameter int unsigned WR_MAX  = 4,
    parameter int unsigned ALL_MAX = 6,
    parameter int unsigned CW      = 3
) (
    input  logic [CW-1:0]   rd_cnt,
    input  logic [CW-1:0]   wr_cnt,
    input  logic            rd_free,
    input  logic            wr_free,
    input  logic [NDIR-1:0] held,
    input  logic [NDIR-1:0] want,
    input  pri_e            pri,
    output logic [NDIR-1:0] admit,
    output logic            clash
);
    localparam int unsigned SW = CW + 2;

    logic [SW-1:0] occ, cap;
    logic one_ok, two_ok, rd_own, wr_own, cand_rd, cand_wr;

    always_comb begin
        occ = SW'(rd_cnt) + SW'(wr_cnt) + SW'(held[DIR_RD]) + SW'(held[DIR_WR]);
        cap = SW'(ALL_MAX) + SW'(rd_free) + SW'(wr_free);
        one_ok = occ < cap;
        two_ok = (occ + SW'(2)) <= cap;
        rd_own = SW'(rd_cnt) < (SW'(RD_MAX) + SW'(rd_free));
        wr_own = SW'(wr_cnt) < (SW'(WR_MAX) + SW'(wr_free));
        cand_rd = want[DIR_RD] & rd_own & one_ok;
        cand_wr = want[DIR_WR] & wr_own & one_ok;
        clash   = cand_rd & cand_wr & ~two_ok;
        admit[DIR_RD] = cand_rd & ~(clash & (pri == PRI_WR));
        admit[DIR_WR] = cand_wr & ~(clash & (pri == PRI_RD));
    end
endmodule

// File: rtl/ostd_burst_limiter.sv
module ostd_burst_limiter
    import ostd_lim_pkg::*;
#(
    parameter int unsigned RD_MAX  = 3,
    parameter int unsigned WR_MAX  = 4,
    parameter int unsigned ALL_MAX = 6,
    parameter int unsigned ADDR_W  = 16,
    localparam int unsigned LIM_HI = (RD_MAX > WR_MAX) ? RD_MAX : WR_MAX,
    localparam int unsigned LIM_TOP = (LIM_HI > ALL_MAX) ? LIM_HI : ALL_MAX,
    localparam int unsigned CW     = $clog2(LIM_TOP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_arvalid,
    output logic              m_arready,
    input  logic [ADDR_W-1:0] m_araddr,
    input  logic              m_awvalid,
    output logic              m_awready,
    input  logic [ADDR_W-1:0] m_awaddr,
    output logic              m_rvalid,
    input  logic              m_rready,
    output logic              m_rlast,
    output logic              m_bvalid,
    input  logic              m_bready,
    output logic              s_arvalid,
    input  logic              s_arready,
    output logic [ADDR_W-1:0] s_araddr,
    output logic              s_awvalid,
    input  logic              s_awready,
    output logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_rvalid,
    output logic              s_rready,
    input  logic              s_rlast,
    input  logic              s_bvalid,
    output logic              s_bready,
    output logic [CW-1:0]     rd_count,
    output logic [CW-1:0]     wr_count
);
    typedef struct packed {
        logic [CW-1:0] rd;
        logic [CW-1:0] wr;
        pri_e          pri;
    } lim_s;

    lim_s st_d, st_q;

    logic [NDIR-1:0] up_valid, dn_ready, dn_valid, up_ready;
    logic [NDIR-1:0] fire, held, want, admit;
    logic            rd_free, wr_free, clash;

    // response channels and payload pass straight through
    assign m_rvalid = s_rvalid;
    assign m_rlast  = s_rlast;
    assign s_rready = m_rready;
    assign m_bvalid = s_bvalid;
    assign s_bready = m_bready;
    assign s_araddr = m_araddr;
    assign s_awaddr = m_awaddr;

    assign rd_free = s_rvalid & m_rready & s_rlast;
    assign wr_free = s_bvalid & m_bready;

    assign up_valid[DIR_RD] = m_arvalid;
    assign up_valid[DIR_WR] = m_awvalid;
    assign dn_ready[DIR_RD] = s_arready;
    assign dn_ready[DIR_WR] = s_awready;
    assign s_arvalid = dn_valid[DIR_RD];
    assign s_awvalid = dn_valid[DIR_WR];
    assign m_arready = up_ready[DIR_RD];
    assign m_awready = up_ready[DIR_WR];

    for (genvar g = 0; g < NDIR; g++) begin : g_chan
        ostd_lim_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (up_valid[g]),
            .dn_ready (dn_ready[g]),
            .admit    (admit[g]),
            .dn_valid (dn_valid[g]),
            .up_ready (up_ready[g]),
            .fire     (fire[g]),
            .held     (held[g]),
            .want     (want[g])
        );
    end

    ostd_lim_admit #(
        .RD_MAX  (RD_MAX),
        .WR_MAX  (WR_MAX),
        .ALL_MAX (ALL_MAX),
        .CW      (CW)
    ) u_admit (
        .rd_cnt  (st_q.rd),
        .wr_cnt  (st_q.wr),
        .rd_free (rd_free),
        .wr_free (wr_free),
        .held    (held),
        .want    (want),
        .pri     (st_q.pri),
        .admit   (admit),
        .clash   (clash)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rd = st_q.rd + CW'(fire[DIR_RD]) - CW'(rd_free);
        st_d.wr = st_q.wr + CW'(fire[DIR_WR]) - CW'(wr_free);
        if (clash) st_d.pri = (st_q.pri == PRI_RD) ? PRI_WR : PRI_RD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.pri <= PRI_RD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_count = st_q.rd;
    assign wr_count = st_q.wr;
endmodule

// File: rtl/ostd_burst_limiter_chk.sv
module ostd_burst_limiter_chk #(
    parameter int unsigned RD_MAX  = 3,
    parameter int unsigned WR_MAX  = 4,
    parameter int unsigned ALL_MAX = 6,
    parameter int unsigned CW      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_arvalid,
    input logic          m_arready,
    input logic          m_awvalid,
    input logic          m_awready,
    input logic          s_arvalid,
    input logic          s_arready,
    input logic          s_awvalid,
    input logic          s_awready,
    input logic          s_rvalid,
    input logic          s_rready,
    input logic          s_rlast,
    input logic          s_bvalid,
    input logic          s_bready,
    input logic [CW-1:0] rd_count,
    input logic [CW-1:0] wr_count
);
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    logic ar_hs, aw_hs, r_end, b_end;
    assign ar_hs = s_arvalid & s_arready;
    assign aw_hs = s_awvalid & s_awready;
    assign r_end = s_rvalid & s_rready & s_rlast;
    assign b_end = s_bvalid & s_bready;

    assert_rd_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ({1'b0, rd_count} <= (CW+1)'(RD_MAX)));
    assert_wr_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ({1'b0, wr_count} <= (CW+1)'(WR_MAX)));
    assert_all_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (({1'b0, rd_count} + {1'b0, wr_count}) <= (CW+1)'(ALL_MAX)));
    assert_ar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && s_arvalid && !s_arready && m_arvalid) |=> (s_arvalid || !m_arvalid));
    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && s_awvalid && !s_awready && m_awvalid) |=> (s_awvalid || !m_awvalid));
    assert_rd_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |=> (rd_count == $past(rd_count) + CW'($past(ar_hs)) - CW'($past(r_end))));
    assert_wr_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |=> (wr_count == $past(wr_count) + CW'($past(aw_hs)) - CW'($past(b_end))));
    assert_ar_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_arready) == ar_hs);
    assert_aw_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && m_awready) == aw_hs);
endmodule

bind ostd_burst_limiter ostd_burst_limiter_chk #(
    .RD_MAX  (RD_MAX),
    .WR_MAX  (WR_MAX),
    .ALL_MAX (ALL_MAX),
    .CW      (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rlast   (s_rlast),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .rd_count  (rd_count),
    .wr_count  (wr_count)
);

// File: tb/ostd_burst_limiter_tb.sv
module ostd_burst_limiter_tb;
    localparam int unsigned AW = 16;
    localparam int unsigned NV = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_arvalid = 0, m_awvalid = 0, m_rready = 0, m_bready = 0;
    logic s_arready = 0, s_awready = 0, s_rvalid = 0, s_rlast = 0, s_bvalid = 0;
    logic [AW-1:0] m_araddr = '0, m_awaddr = '0;
    logic m_arready, m_awready, m_rvalid, m_rlast, m_bvalid;
    logic s_arvalid, s_awvalid, s_rready, s_bready;
    logic [AW-1:0] s_araddr, s_awaddr;
    logic [2:0] rd_count, wr_count;

    ostd_burst_limiter #(.RD_MAX(3), .WR_MAX(4), .ALL_MAX(6), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rlast(m_rlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rlast(s_rlast),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .rd_count(rd_count), .wr_count(wr_count)
    );

    // inputs: arv awv ars aws rlast-beat plain-beat bresp
    // expected: m_arready m_awready s_arvalid s_awvalid rd wr (after the edge)
    typedef struct packed {
        logic arv, awv, ars, aws, rl, rnl, bv;
        logic e_arr, e_awr, e_sar, e_saw;
        logic [3:0] e_rd, e_wr;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd1,4'd0}, // 0 R2
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd2,4'd0},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd3,4'd0},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd3,4'd0}, // 3 R4
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd3,4'd0}, // 4 R2 plain beat
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd3,4'd0}, // 5 R7
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd2,4'd0},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd1,4'd0},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd1,4'd1}, // 8 R3
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd1,4'd2},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd1,4'd3},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd1,4'd4},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd1,4'd4}, // 12 R5
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd1,4'd4}, // 13 R7
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd1,4'd3},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd2,4'd3},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd3,4'd3},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd3,4'd3}, // 17 R6
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd2,4'd4}, // 18 R7 cross
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd2,4'd3},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd3,4'd3}, // 20 R8 read wins
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1, 4'd2,4'd2}, // 21 write held
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b1, 4'd3,4'd2}, // 22 R9
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd3,4'd3}, // 23 R9 full
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd2,4'd3},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd2,4'd4}, // 25 R8 write wins
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0, 4'd2,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd1,4'd3}
    };

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        m_arvalid = 0; m_awvalid = 0; s_arready = 0; s_awready = 0;
        s_rvalid = 0; s_rlast = 0; s_bvalid = 0;
    endtask

    initial begin
        m_rready = 1; m_bready = 1;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: counters zero after reset
        chk(rd_count == 0, "R1 rd after reset", int'(rd_count), 0);
        chk(wr_count == 0, "R1 wr after reset", int'(wr_count), 0);
        rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            m_arvalid = TBL[i].arv; m_awvalid = TBL[i].awv;
            s_arready = TBL[i].ars; s_awready = TBL[i].aws;
            s_rvalid  = TBL[i].rl | TBL[i].rnl; s_rlast = TBL[i].rl;
            s_bvalid  = TBL[i].bv;
            m_araddr  = AW'(16'hA000 + i); m_awaddr = AW'(16'h5000 + i);
            #1;
            chk(m_arready == TBL[i].e_arr, $sformatf("R4/R6/R8 m_arready row %0d", i), int'(m_arready), int'(TBL[i].e_arr));
            chk(m_awready == TBL[i].e_awr, $sformatf("R5/R6/R8 m_awready row %0d", i), int'(m_awready), int'(TBL[i].e_awr));
            chk(s_arvalid == TBL[i].e_sar, $sformatf("R4/R9 s_arvalid row %0d", i), int'(s_arvalid), int'(TBL[i].e_sar));
            chk(s_awvalid == TBL[i].e_saw, $sformatf("R5/R9 s_awvalid row %0d", i), int'(s_awvalid), int'(TBL[i].e_saw));
            chk(s_araddr == m_araddr && s_awaddr == m_awaddr, $sformatf("R10 address row %0d", i), int'(s_araddr), int'(m_araddr));
            chk(m_rvalid == s_rvalid && m_rlast == s_rlast && s_rready == m_rready
                && m_bvalid == s_bvalid && s_bready == m_bready,
                $sformatf("R11 response pass row %0d", i), int'(m_rvalid), int'(s_rvalid));
            @(posedge clk);
            #1;
            chk(rd_count == TBL[i].e_rd[2:0], $sformatf("R2/R7 rd_count row %0d", i), int'(rd_count), int'(TBL[i].e_rd));
            chk(wr_count == TBL[i].e_wr[2:0], $sformatf("R3/R7 wr_count row %0d", i), int'(wr_count), int'(TBL[i].e_wr));
        end
        // R1: reset from a non-empty state clears both counters
        @(negedge clk);
        drive_idle();
        rst_n = 0;
        @(posedge clk);
        #1;
        chk(rd_count == 0, "R1 rd after mid reset", int'(rd_count), 0);
        chk(wr_count == 0, "R1 wr after mid reset", int'(wr_count), 0);
        @(negedge clk);
        rst_n = 1;
        // R1/R2: fresh read accepted right after reset
        m_arvalid = 1; s_arready = 1;
        #1;
        chk(m_arready == 1, "R1 ready after reset", int'(m_arready), 1);
        @(posedge clk);
        #1;
        chk(rd_count == 1, "R2 rd after reset accept", int'(rd_count), 1);
        @(negedge clk);
        drive_idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule